// File: doc/BRIEF.md
# Stacked Interrupt Status Controller

This block gathers interrupt events from two engines, a bus-protocol engine and a DMA engine, and holds them in latched detail registers. A host reads them over a byte-wide register port. A summary register shows one pending bit for each engine and a software flag bit. An active-low interrupt line is driven from the summary bits that the host has enabled in a mask register. Reading an engine's clearing detail register clears that engine's pending condition.

Events can arrive while an engine's detail register still holds status the host has not cleared. Those events go into a one-deep stack register for that engine. When the clearing read completes, the stacked events are moved into the detail register, so the pending bit and the interrupt line come back at once.

A clearing read starts a settle window. A small controller with two states, READY and SETTLE, models it. The ACCEPT transition (READY to SETTLE) fires on a clearing read that actually clears. The EXPIRE transition (SETTLE to READY) fires once the window has run out. A clearing read that arrives while the controller is in SETTLE returns its data but clears nothing.

Top module: `stacked_irq_ctrl`

## Requirements
- R1: After reset, every detail, stack, flag and mask register is zero, `rdata` is zero and `irq_n` is high.
- R2: A pulse on `fly_evt` sets the flag (summary bit 2). Writing a value with bit 2 set to address 0 clears the flag, and writing a value with bit 2 clear leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R3: Bus events latch into a 16-bit detail register. Address 1 returns bits 7:0 and does not clear. Address 2 returns bits 15:8 and is the clearing read for the bus engine. Summary bit 0 is set while the bus detail is non-zero.
- R4: DMA events latch into an 8-bit detail register. Address 3 returns it and is the clearing read for the DMA engine. Summary bit 1 is set while the DMA detail is non-zero.
- R5: Both pending bits can be set at once. Each one clears only through its own clearing read.
- R6: An event that arrives while its engine's detail is non-zero is ORed into that engine's stack and is not visible in the detail register. The clearing read moves the stack into the detail register, so the pending bit stays set and `irq_n` stays low.
- R7: An accepted clearing read on either engine starts a shared window of 12 cycles. A clearing read taken 1 to 11 cycles after it returns data but changes nothing. A clearing read taken 12 cycles after it is accepted.
- R8: The mask register at address 4 (bit 0 bus, bit 1 DMA, bit 2 flag) can be written and read back. `irq_n` is low exactly when some enabled summary bit is set.
- R9: A clearing read that finds the detail at zero changes no detail or stack register and does not start the settle window.
- R10: If a clearing read and a new event for the same engine fall in the same cycle, the new detail holds the old stack ORed with the new event.
- R11: `rdata` is registered. It shows the addressed value in the cycle after `rd_en`, taken before any clear made by that read. Unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| bus_evt | input | 16 | Bus-protocol event strobes, one per bit |
| dma_evt | input | 8 | DMA event strobes, one per bit |
| fly_evt | input | 1 | Software flag set strobe |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Two functions can fall in the same cycle. A clearing read can coincide with a new event for the same engine, and a flag-clear write can coincide with a flag-set pulse. The bench provokes both by driving the read or write strobe and the event strobe on the same edge. It then reads the registers back afterwards, expecting the event merged into the promoted detail in the first case and the flag still set in the second.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int BUS_W = 16;
    localparam int DMA_W = 8;

    localparam logic [2:0] ADR_SUM    = 3'd0;
    localparam logic [2:0] ADR_BUS_LO = 3'd1;
    localparam logic [2:0] ADR_BUS_HI = 3'd2;
    localparam logic [2:0] ADR_DMA    = 3'd3;
    localparam logic [2:0] ADR_MASK   = 3'd4;

    typedef enum logic {
        ST_READY,
        ST_SETTLE
    } settle_st_t;
endpackage

// File: rtl/sic_src_stack.sv
module sic_src_stack #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr,
    output logic [W-1:0] detail,
    output logic         pend,
    output logic         stack_empty
);
    logic [W-1:0] stack_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            detail  <= '0;
            stack_q <= '0;
        end else if (clr) begin
            detail  <= stack_q | evt;
            stack_q <= '0;
        end else if (detail != '0) begin
            stack_q <= stack_q | evt;
        end else begin
            detail  <= evt;
        end
    end

    assign pend        = (detail != '0);
    assign stack_empty = (stack_q == '0);
endmodule

// File: rtl/sic_settle_fsm.sv
module sic_settle_fsm
    import sic_pkg::*;
#(
    parameter int SETTLE = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    output logic ready
);
    localparam int CW = (SETTLE > 2) ? $clog2(SETTLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE - 2);

    settle_st_t st_q, st_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_READY:  if (accept)        st_d = ST_SETTLE;
            ST_SETTLE: if (cnt_q == LAST) st_d = ST_READY;
            default:                      st_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_READY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= (st_q == ST_SETTLE) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        ready = (st_q == ST_READY);
    end
endmodule

// File: rtl/stacked_irq_ctrl.sv
module stacked_irq_ctrl
    import sic_pkg::*;
#(
    parameter int SETTLE_CYC = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [BUS_W-1:0] bus_evt,
    input  logic [DMA_W-1:0] dma_evt,
    input  logic             fly_evt,
    output logic             irq_n
);
    logic [BUS_W-1:0] bus_det;
    logic [DMA_W-1:0] dma_det;
    logic bus_pend, dma_pend, bus_stk_empty, dma_stk_empty;
    logic settle_ready, clr_bus, clr_dma;
    logic fly_flag;
    logic [2:0] mask;
    logic [2:0] summary;
    logic [7:0] rd_mux;

    assign clr_bus = rd_en && (addr == ADR_BUS_HI) && settle_ready && bus_pend;
    assign clr_dma = rd_en && (addr == ADR_DMA)    && settle_ready && dma_pend;

    sic_src_stack #(.W(BUS_W)) i_bus (
        .clk(clk), .rst_n(rst_n), .evt(bus_evt), .clr(clr_bus),
        .detail(bus_det), .pend(bus_pend), .stack_empty(bus_stk_empty)
    );

    sic_src_stack #(.W(DMA_W)) i_dma (
        .clk(clk), .rst_n(rst_n), .evt(dma_evt), .clr(clr_dma),
        .detail(dma_det), .pend(dma_pend), .stack_empty(dma_stk_empty)
    );

    sic_settle_fsm #(.SETTLE(SETTLE_CYC)) i_settle (
        .clk(clk), .rst_n(rst_n), .accept(clr_bus | clr_dma), .ready(settle_ready)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fly_flag <= 1'b0;
            mask     <= '0;
        end else begin
            if (fly_evt)
                fly_flag <= 1'b1;
            else if (wr_en && addr == ADR_SUM && wdata[2])
                fly_flag <= 1'b0;
            if (wr_en && addr == ADR_MASK)
                mask <= wdata[2:0];
        end
    end

    assign summary = {fly_flag, dma_pend, bus_pend};

    always_comb begin
        unique case (addr)
            ADR_SUM:    rd_mux = {5'b0, summary};
            ADR_BUS_LO: rd_mux = bus_det[7:0];
            ADR_BUS_HI: rd_mux = bus_det[15:8];
            ADR_DMA:    rd_mux = dma_det;
            ADR_MASK:   rd_mux = {5'b0, mask};
            default:    rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= 8'h00;
        else if (rd_en)
            rdata <= rd_mux;
    end

    assign irq_n = ~|(summary & mask);
endmodule

// File: rtl/sic_checker.sv
module sic_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic [2:0] addr,
    input logic [7:0] dma_evt,
    input logic       fly_evt,
    input logic       irq_n,
    input logic       bus_pend,
    input logic       dma_pend,
    input logic       fly_flag,
    input logic [2:0] mask,
    input logic       dma_stk_empty,
    input logic       settle_ready
);
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 3'b000) |-> irq_n);

    a_r1_irq_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (bus_pend || dma_pend || fly_flag));

    a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        fly_evt |=> fly_flag);

    a_r4_dma_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd3 && settle_ready && dma_pend && dma_stk_empty && dma_evt == '0)
        |=> !dma_pend);

    a_r6_stack_promote: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd3 && settle_ready && dma_pend && !dma_stk_empty) |=> dma_pend);

    a_r7_settle_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd3 && !settle_ready && dma_pend) |=> dma_pend);

    a_r9_zero_read_no_window: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd3 && !dma_pend && settle_ready && !(rd_en && addr == 3'd2))
        |=> settle_ready);
endmodule

bind stacked_irq_ctrl sic_checker i_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .dma_evt(dma_evt),
    .fly_evt(fly_evt), .irq_n(irq_n), .bus_pend(bus_pend), .dma_pend(dma_pend),
    .fly_flag(fly_flag), .mask(mask), .dma_stk_empty(dma_stk_empty),
    .settle_ready(settle_ready)
);

// File: tb/test_stacked_irq_ctrl.sv
module test_stacked_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0, fly_evt = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [15:0] bus_evt = '0;
    logic [7:0]  dma_evt = '0;
    logic [7:0]  rdata;
    logic        irq_n;
    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    stacked_irq_ctrl i_stacked_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .bus_evt(bus_evt), .dma_evt(dma_evt),
        .fly_evt(fly_evt), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bev(input logic [15:0] v);
        bus_evt = v; @(negedge clk); bus_evt = '0;
    endtask

    task automatic dev(input logic [7:0] v);
        dma_evt = v; @(negedge clk); dma_evt = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 rdata", rdata, 8'h00);
        check("R1 irq_n", irq_n, 1'b1);
        rd(3'd0, d); check("R1 summary", d, 8'h00);
        rd(3'd3, d); check("R1 dma", d, 8'h00);
        rd(3'd4, d); check("R1 mask", d, 8'h00);
        rd(3'd6, d); check("R11 unused addr", d, 8'h00);
        wr(3'd4, 8'h07);
        rd(3'd4, d); check("R8 mask readback", d, 8'h07);
    endtask

    task automatic t_flag();
        logic [7:0] d;
        fly_evt = 1'b1; @(negedge clk); fly_evt = 1'b0;
        rd(3'd0, d); check("R2 flag set", d, 8'h04);
        check("R2 irq low", irq_n, 1'b0);
        wr(3'd0, 8'h03);
        rd(3'd0, d); check("R2 write zero keeps", d, 8'h04);
        wr(3'd0, 8'h04);
        rd(3'd0, d); check("R2 w1c", d, 8'h00);
        check("R2 irq high", irq_n, 1'b1);
        addr = 3'd0; wdata = 8'h04; wr_en = 1'b1; fly_evt = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; fly_evt = 1'b0;
        rd(3'd0, d); check("R2 set wins", d, 8'h04);
        wr(3'd0, 8'h04);
    endtask

    task automatic t_bus();
        logic [7:0] d;
        idle(12);
        bev(16'hA53C);
        rd(3'd0, d); check("R3 pending", d, 8'h01);
        rd(3'd1, d); check("R3 low byte", d, 8'h3C);
        rd(3'd0, d); check("R3 low read keeps", d, 8'h01);
        rd(3'd2, d); check("R3 high byte", d, 8'hA5);
        rd(3'd0, d); check("R3 cleared", d, 8'h00);
        check("R3 irq high", irq_n, 1'b1);
    endtask

    task automatic t_dma();
        logic [7:0] d;
        idle(12);
        dev(8'h81);
        rd(3'd0, d); check("R4 pending", d, 8'h02);
        rd(3'd3, d); check("R4 detail", d, 8'h81);
        rd(3'd0, d); check("R4 cleared", d, 8'h00);
        rd(3'd3, d); check("R4 detail zero", d, 8'h00);
    endtask

    task automatic t_both();
        logic [7:0] d;
        idle(12);
        bev(16'h0100);
        dev(8'h40);
        rd(3'd0, d); check("R5 both", d, 8'h03);
        rd(3'd3, d); check("R5 dma data", d, 8'h40);
        rd(3'd0, d); check("R5 bus remains", d, 8'h01);
        check("R5 irq low", irq_n, 1'b0);
        idle(12);
        rd(3'd2, d); check("R5 bus data", d, 8'h01);
        rd(3'd0, d); check("R5 none", d, 8'h00);
    endtask

    task automatic t_stack();
        logic [7:0] d;
        idle(12);
        dev(8'h01);
        dev(8'h02);
        rd(3'd3, d); check("R6 first only", d, 8'h01);
        rd(3'd0, d); check("R6 promoted pending", d, 8'h02);
        check("R6 irq again", irq_n, 1'b0);
        idle(12);
        rd(3'd3, d); check("R6 stacked data", d, 8'h02);
        rd(3'd0, d); check("R6 drained", d, 8'h00);
        check("R6 irq high", irq_n, 1'b1);
    endtask

    task automatic t_settle();
        logic [7:0] d;
        idle(12);
        bev(16'h0100);
        dev(8'h04);
        rd(3'd2, d); check("R7 accepted read", d, 8'h01);
        idle(10);
        rd(3'd3, d); check("R7 read at 11", d, 8'h04);
        rd(3'd3, d); check("R7 not cleared at 11", d, 8'h04);
        rd(3'd0, d); check("R7 cleared at 12", d, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        idle(12);
        wr(3'd4, 8'h00);
        fly_evt = 1'b1; @(negedge clk); fly_evt = 1'b0;
        check("R8 masked irq", irq_n, 1'b1);
        rd(3'd0, d); check("R8 status visible", d, 8'h04);
        wr(3'd4, 8'h04);
        check("R8 enabled irq", irq_n, 1'b0);
        wr(3'd4, 8'h03);
        check("R8 other bits", irq_n, 1'b1);
        wr(3'd0, 8'h04);
        wr(3'd4, 8'h07);
    endtask

    task automatic t_zero();
        logic [7:0] d;
        idle(12);
        rd(3'd3, d); check("R9 zero read", d, 8'h00);
        dev(8'h10);
        rd(3'd3, d); check("R9 data", d, 8'h10);
        rd(3'd0, d); check("R9 no window", d, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        idle(12);
        bev(16'h0002);
        addr = 3'd2; rd_en = 1'b1; bus_evt = 16'h0004;
        @(negedge clk);
        rd_en = 1'b0; bus_evt = '0;
        check("R11 pre-clear data", rdata, 8'h00);
        rd(3'd0, d); check("R10 still pending", d, 8'h01);
        rd(3'd1, d); check("R10 merged event", d, 8'h04);
        idle(12);
        rd(3'd2, d);
        rd(3'd0, d); check("R10 drained", d, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flag();
        t_bus();
        t_dma();
        t_both();
        t_stack();
        t_settle();
        t_mask();
        t_zero();
        t_collide();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule